// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence engine attached to one private cache in a small multiprocessor whose caches share a single bus. It tracks a small window of line addresses, each holding one data word and a coherence state of Invalid, Shared or Modified. Local processor loads and stores either complete locally or cause the controller to arbitrate for the bus and issue a read, a read-for-ownership write, or an address-only upgrade.

At the same time it watches the transactions that the other caches place on the bus. A snooped transaction that touches a line held here can invalidate the line, or can make the controller hand its Modified data to the requester. On a snooped read, that data also goes back to memory.

The processor holds its request until it sees a completion pulse. The bus arbiter, the other caches and memory sit outside the block. Line addresses index the line store directly, so the store never has to replace a line.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, cpu_done and supply_valid are low. The first access to any line therefore misses.
- R2: A processor read of an Invalid line raises bus_req with bus_cmd 01 (read) at the line address. Command and address hold until bus_gnt. After the grant, the word in the bus response returns to the processor and the line becomes Shared.
- R3: A processor read of a Shared or Modified line completes with cpu_done one cycle after acceptance. It raises no bus request, returns the stored word and leaves the state unchanged.
- R4: A processor write to a Shared line issues bus_cmd 11 (upgrade). It completes on the cycle after the grant without waiting for a data response, and the line becomes Modified and holds the new word.
- R5: A processor write to an Invalid line issues bus_cmd 10 (write, read-for-ownership). After the response the line is Modified and holds the written word.
- R6: A snooped read (snp_cmd 01) that hits a Shared line causes no supply and leaves the line Shared.
- R7: A snooped read that hits a Modified line raises supply_valid and supply_wb one cycle later, carrying the line's word, and the line becomes Shared.
- R8: A snooped write (10) or upgrade (11) that hits a Shared line invalidates it. A snooped write that hits a Modified line supplies the word with supply_wb low, and the line becomes Invalid.
- R9: A snooped transaction to the address of the processor request in the same cycle is handled first, and the processor request stalls. A snooped write or upgrade to the line of a pending, ungranted upgrade turns that upgrade into bus_cmd 10.
- R10: cpu_src_cache copies bus_resp_owner for a miss served from the bus. It is 0 for local hits and upgrades.
- R11: A processor write to a Modified line completes one cycle after acceptance with no bus request, and the new word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | AW | Line address |
| cpu_wdata | input | DW | Write word |
| cpu_stall | output | 1 | Request pending and not yet done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| cpu_src_cache | output | 1 | Data for this access came from another cache |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write, 11 upgrade |
| bus_addr | output | AW | Address of the bus transaction |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_resp_valid | input | 1 | Data response for a read or write |
| bus_resp_data | input | DW | Response word |
| bus_resp_owner | input | 1 | Response supplied by an owning cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | AW | Snooped address |
| supply_valid | output | 1 | This cache is supplying data |
| supply_data | output | DW | Supplied word |
| supply_wb | output | 1 | Memory must also take the supplied word |

## Verification
A local hit raises cpu_done on the cycle after the acceptance edge. A granted upgrade completes on the cycle after the grant edge. A read or write miss completes on the cycle after the edge that samples the response. A snoop's supply output appears on the cycle after the snoop is sampled. The bench drives all inputs on the falling edge, samples each result on the falling edge of the cycle in which it is due, and answers grants and responses only when bus_req is seen. Line states are inferred at the ports from the bus command the next processor access produces.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_M = 2'd2} line_st_e;
  typedef enum logic [1:0] {F_IDLE, F_ARB, F_WAIT, F_DONE} fsm_e;
  localparam logic [1:0] BC_IDLE = 2'b00;
  localparam logic [1:0] BC_RD   = 2'b01;
  localparam logic [1:0] BC_WR   = 2'b10;
  localparam logic [1:0] BC_UPG  = 2'b11;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DW     = 16,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_idx,
  output line_st_e      cpu_st,
  output logic [DW-1:0] cpu_data,
  input  logic [AW-1:0] snp_idx,
  output line_st_e      snp_st,
  output logic [DW-1:0] snp_data,
  input  logic          fw_en,
  input  logic [AW-1:0] fw_idx,
  input  line_st_e      fw_st,
  input  logic          fw_data_en,
  input  logic [DW-1:0] fw_data,
  input  logic          sw_en,
  input  line_st_e      sw_st
);
  line_st_e    st_q  [NLINES];
  logic [DW-1:0] dat_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit_f, hit_s;
    assign hit_f = fw_en && (fw_idx == AW'(g));
    assign hit_s = sw_en && (snp_idx == AW'(g));

    // Processor-side update wins over a snoop to the same line in one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[g] <= LN_I;
      else if (hit_f) st_q[g] <= fw_st;
      else if (hit_s) st_q[g] <= sw_st;
    end

    always_ff @(posedge clk) begin
      if (hit_f && fw_data_en) dat_q[g] <= fw_data;
    end
  end

  assign cpu_st   = st_q[cpu_idx];
  assign cpu_data = dat_q[cpu_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_data = dat_q[snp_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  line_st_e      snp_st,
  input  logic [DW-1:0] snp_data,
  output logic          sw_en,
  output line_st_e      sw_st,
  output logic          supply_valid,
  output logic [DW-1:0] supply_data,
  output logic          supply_wb
);
  logic sup_n, wb_n;

  always_comb begin
    sw_en = 1'b0;
    sw_st = snp_st;
    sup_n = 1'b0;
    wb_n  = 1'b0;
    if (snp_valid) begin
      unique case (snp_cmd)
        BC_RD: if (snp_st == LN_M) begin
          sw_en = 1'b1; sw_st = LN_S; sup_n = 1'b1; wb_n = 1'b1;
        end
        BC_WR: if (snp_st != LN_I) begin
          sw_en = 1'b1; sw_st = LN_I; sup_n = (snp_st == LN_M);
        end
        BC_UPG: if (snp_st != LN_I) begin
          sw_en = 1'b1; sw_st = LN_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_valid <= 1'b0;
      supply_wb    <= 1'b0;
    end else begin
      supply_valid <= sup_n;
      supply_wb    <= wb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (sup_n) supply_data <= snp_data;
  end

  p_rd_m_supplies_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == BC_RD && snp_st == LN_M
      |=> supply_valid && supply_wb && supply_data == $past(snp_data));
  p_no_supply_from_s_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_st != LN_M |=> !supply_valid);
  p_wr_supply_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == BC_WR |=> !supply_wb);
endmodule

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
  import msi_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_src_cache,
  input  line_st_e      cpu_st,
  input  logic [DW-1:0] cpu_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_resp_valid,
  input  logic [DW-1:0] bus_resp_data,
  input  logic          bus_resp_owner,
  output logic          fw_en,
  output logic [AW-1:0] fw_idx,
  output line_st_e      fw_st,
  output logic          fw_data_en,
  output logic [DW-1:0] fw_data
);
  fsm_e          fsm_q, fsm_n;
  logic [1:0]    cmd_q, cmd_n;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_n;
  logic          src_q, src_n;
  logic          accept, conv, cmd_en, out_en;

  assign accept = (fsm_q == F_IDLE) && cpu_req && !(snp_valid && snp_addr == cpu_addr);
  assign conv   = (fsm_q == F_ARB) && !bus_gnt && cmd_q == BC_UPG && snp_valid &&
                  snp_addr == addr_q && (snp_cmd == BC_WR || snp_cmd == BC_UPG);

  always_comb begin
    fsm_n = fsm_q;  cmd_n = cmd_q;  cmd_en = 1'b0;
    rdata_n = rdata_q;  src_n = 1'b0;  out_en = 1'b0;
    fw_en = 1'b0;  fw_idx = addr_q;  fw_st = LN_M;  fw_data_en = 1'b0;  fw_data = wdata_q;
    unique case (fsm_q)
      F_IDLE: if (accept) begin
        cmd_en = 1'b1;
        if (!cpu_we && cpu_st != LN_I) begin
          fsm_n = F_DONE; out_en = 1'b1; rdata_n = cpu_data;
        end else if (cpu_we && cpu_st == LN_M) begin
          fsm_n = F_DONE; out_en = 1'b1; rdata_n = cpu_wdata;
          fw_en = 1'b1; fw_idx = cpu_addr; fw_data_en = 1'b1; fw_data = cpu_wdata;
        end else begin
          fsm_n = F_ARB;
          cmd_n = !cpu_we ? BC_RD : (cpu_st == LN_S ? BC_UPG : BC_WR);
        end
      end
      F_ARB: begin
        if (bus_gnt) begin
          if (cmd_q == BC_UPG) begin
            fsm_n = F_DONE; out_en = 1'b1; rdata_n = wdata_q;
            fw_en = 1'b1; fw_data_en = 1'b1;
          end else fsm_n = F_WAIT;
        end else if (conv) begin
          cmd_en = 1'b1; cmd_n = BC_WR;
        end
      end
      F_WAIT: if (bus_resp_valid) begin
        fsm_n = F_DONE; out_en = 1'b1; src_n = bus_resp_owner;
        rdata_n = we_q ? wdata_q : bus_resp_data;
        fw_en = 1'b1; fw_data_en = 1'b1;
        fw_st = we_q ? LN_M : LN_S;
        fw_data = we_q ? wdata_q : bus_resp_data;
      end
      F_DONE: fsm_n = F_IDLE;
      default: fsm_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_n;
  end

  always_ff @(posedge clk) begin
    if (cmd_en) cmd_q <= cmd_n;
    if (accept) begin
      addr_q  <= cpu_addr;
      we_q    <= cpu_we;
      wdata_q <= cpu_wdata;
    end
    if (out_en) begin
      rdata_q <= rdata_n;
      src_q   <= src_n;
    end
  end

  assign cpu_done      = (fsm_q == F_DONE);
  assign cpu_rdata     = rdata_q;
  assign cpu_src_cache = src_q;
  assign bus_req       = (fsm_q == F_ARB);
  assign bus_cmd       = bus_req ? cmd_q : BC_IDLE;
  assign bus_addr      = addr_q;

  p_hit_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cpu_we && cpu_st != LN_I |=> cpu_done && !bus_req);
  p_wr_m_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_we && cpu_st == LN_M |=> cpu_done && !bus_req);
  p_upg_no_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == BC_UPG |=> cpu_done);
  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));
  p_upg_becomes_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv |=> bus_req && bus_cmd == BC_WR);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DW     = 16,
  localparam int AW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_src_cache,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_resp_valid,
  input  logic [DW-1:0] bus_resp_data,
  input  logic          bus_resp_owner,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          supply_valid,
  output logic [DW-1:0] supply_data,
  output logic          supply_wb
);
  line_st_e      cpu_st, snp_st, fw_st, sw_st;
  logic [DW-1:0] cpu_data, snp_data, fw_data;
  logic          fw_en, fw_data_en, sw_en;
  logic [AW-1:0] fw_idx;

  msi_line_array #(.NLINES(NLINES), .DW(DW), .AW(AW)) u_lines (
    .clk, .rst_n, .cpu_idx(cpu_addr), .cpu_st, .cpu_data,
    .snp_idx(snp_addr), .snp_st, .snp_data,
    .fw_en, .fw_idx, .fw_st, .fw_data_en, .fw_data, .sw_en, .sw_st
  );

  msi_snoop_unit #(.DW(DW)) u_snoop (
    .clk, .rst_n, .snp_valid, .snp_cmd, .snp_st, .snp_data,
    .sw_en, .sw_st, .supply_valid, .supply_data, .supply_wb
  );

  msi_ctrl_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_done, .cpu_rdata, .cpu_src_cache, .cpu_st, .cpu_data,
    .snp_valid, .snp_cmd, .snp_addr,
    .bus_req, .bus_cmd, .bus_addr, .bus_gnt, .bus_resp_valid, .bus_resp_data, .bus_resp_owner,
    .fw_en, .fw_idx, .fw_st, .fw_data_en, .fw_data
  );

  assign cpu_stall = cpu_req && !cpu_done;
endmodule

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_stall, cpu_done, cpu_src_cache;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_resp_valid = 0, bus_resp_owner = 0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_resp_data = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic supply_valid, supply_wb;
  logic [DW-1:0] supply_data;

  always #2.5 clk = ~clk;

  msi_snoop_ctrl #(.NLINES(NL), .DW(DW)) u0 (.*);

  int n_chk = 0, n_err = 0, cyc = 0;
  int st[NL];             // 0 I, 1 S, 2 M
  logic [DW-1:0] dat[NL], mem[NL], oth_dat[NL];
  bit oth_m[NL];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL all watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [1:0] exp_cmd(bit we, int s);
    if (!we) return (s == 0) ? 2'b01 : 2'b00;
    return (s == 2) ? 2'b00 : (s == 1) ? 2'b11 : 2'b10;
  endfunction

  // Processor access; conv injects a snooped write during a pending upgrade,
  // with_snp drives a snooped read to the same line in the request cycle.
  task automatic cpu_op(bit we, int a, logic [DW-1:0] wd, bit conv, bit with_snp, string tag);
    logic [1:0] ec;
    bit granted = 0, need_resp = 0, resp_sent = 0, injected = 0, saw_bus = 0, first = 1;
    bit exp_src = 0, sup_exp = 0;
    logic [DW-1:0] exp_rd, sup_dat = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
    if (with_snp) begin
      snp_valid = 1; snp_cmd = 2'b01; snp_addr = AW'(a);
      sup_exp = (st[a] == 2); sup_dat = dat[a];
      if (st[a] == 2) begin mem[a] = dat[a]; st[a] = 1; end
    end
    ec = exp_cmd(we, st[a]);
    exp_rd = dat[a];
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      bus_gnt = 0; bus_resp_valid = 0;
      if (first && with_snp) begin
        snp_valid = 0;
        chk(supply_valid == sup_exp && (!sup_exp || (supply_wb && supply_data == sup_dat)),
            "R9", "snoop served before same-line request", supply_valid, sup_exp);
      end
      if (injected) snp_valid = 0;
      first = 0;
      if (cpu_done) begin
        if (!we) chk(cpu_rdata == exp_rd, tag, "read data", cpu_rdata, exp_rd);
        chk(saw_bus == (ec != 2'b00), tag, "bus used", saw_bus, ec != 2'b00);
        chk(cpu_src_cache == exp_src, "R10", "source flag", cpu_src_cache, exp_src);
        cpu_req = 0;
        if (we) begin dat[a] = wd; st[a] = 2; end
        else if (st[a] == 0) begin dat[a] = exp_rd; st[a] = 1; end
        return;
      end
      if (bus_req && !granted) begin
        if (conv && !injected && bus_cmd == 2'b11) begin
          injected = 1;
          snp_valid = 1; snp_cmd = 2'b10; snp_addr = AW'(a);
          st[a] = 0; oth_m[a] = 1; oth_dat[a] = DW'($urandom);
          ec = 2'b10;
        end else begin
          saw_bus = 1;
          chk(bus_cmd == ec && bus_addr == AW'(a), tag, "bus command",
              {bus_cmd, 5'(bus_addr)}, {ec, 5'(a)});
          bus_gnt = 1; granted = 1;
          need_resp = (ec != 2'b11);
        end
      end else if (granted && need_resp && !resp_sent) begin
        resp_sent = 1; bus_resp_valid = 1;
        if (oth_m[a]) begin
          bus_resp_data = oth_dat[a]; bus_resp_owner = 1; exp_src = 1;
          if (!we) mem[a] = oth_dat[a];
          oth_m[a] = 0;
        end else begin
          bus_resp_data = mem[a]; bus_resp_owner = 0; exp_src = 0;
        end
        exp_rd = bus_resp_data;
        if (we) oth_m[a] = 0;
      end
    end
    chk(0, tag, "request never completed", 0, 1);
    cpu_req = 0;
  endtask

  task automatic snoop(logic [1:0] c, int a, string tag);
    bit sv, swb;
    logic [DW-1:0] sd;
    sv  = (st[a] == 2) && (c != 2'b11);
    swb = (st[a] == 2) && (c == 2'b01);
    sd  = dat[a];
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = AW'(a);
    @(negedge clk);
    snp_valid = 0;
    chk(supply_valid == sv && supply_wb == swb && (!sv || supply_data == sd), tag,
        "supply", {supply_valid, supply_wb}, {sv, swb});
    if (c == 2'b01) begin
      if (st[a] == 2) begin mem[a] = dat[a]; st[a] = 1; end
      if (oth_m[a]) begin mem[a] = oth_dat[a]; oth_m[a] = 0; end
    end else begin
      st[a] = 0; oth_m[a] = 1; oth_dat[a] = DW'($urandom);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < NL; i++) begin
      st[i] = 0; oth_m[i] = 0; mem[i] = DW'(16'h1000 + i); dat[i] = '0; oth_dat[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!bus_req && !cpu_done && !supply_valid, "R1", "outputs in reset",
        {bus_req, cpu_done, supply_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !cpu_done && !supply_valid && !cpu_stall, "R1", "idle after reset",
        {bus_req, cpu_done, supply_valid}, 0);

    cpu_op(0, 3, '0, 0, 0, "R2");            // miss, memory data, Shared
    cpu_op(0, 3, '0, 0, 0, "R3");            // hit on Shared
    snoop(2'b01, 3, "R6");                   // no action on Shared
    cpu_op(0, 3, '0, 0, 0, "R6");            // still a local hit
    cpu_op(1, 3, 16'hBEEF, 0, 0, "R4");      // upgrade
    cpu_op(0, 3, '0, 0, 0, "R3");            // hit on Modified
    cpu_op(1, 3, 16'hCAFE, 0, 0, "R11");     // write hit Modified
    snoop(2'b01, 3, "R7");                   // supply + writeback
    cpu_op(1, 3, 16'h1234, 0, 0, "R7");      // line is Shared: upgrade
    snoop(2'b10, 3, "R8");                   // Modified -> supply, Invalid
    cpu_op(0, 3, '0, 0, 0, "R8");            // read miss, owner supplies
    snoop(2'b11, 3, "R8");                   // Shared -> Invalid
    cpu_op(1, 3, 16'h5A5A, 0, 0, "R5");      // write miss
    cpu_op(0, 5, '0, 0, 0, "R2");
    cpu_op(1, 5, 16'h7777, 1, 0, "R9");      // pending upgrade becomes write
    cpu_op(0, 5, '0, 0, 0, "R9");
    cpu_op(1, 6, 16'h0606, 0, 0, "R5");
    cpu_op(0, 6, '0, 0, 1, "R9");            // snoop wins, then local hit

    for (int n = 0; n < 400; n++) begin
      int a, r;
      a = int'($urandom_range(NL - 1));
      r = int'($urandom_range(9));
      if (r < 3)      cpu_op(0, a, '0, 0, 0, "R3");
      else if (r < 6) cpu_op(1, a, DW'($urandom), r == 5, 0, "R5");
      else if (r == 6) cpu_op(0, a, '0, 0, 1, "R9");
      else begin
        logic [1:0] c;
        c = 2'($urandom_range(3));
        if (c == 2'b00 || (c == 2'b11 && st[a] == 2)) c = 2'b01;
        snoop(c, a, "R8");
      end
    end
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule